// File: doc/BRIEF.md
# Power-Down and Clock Source Controller

This block sits beside the clock tree of a small microcontroller-style chip. It holds the enable bits of the four clock sources: an external 4–24 MHz crystal, a PLL output, a fast 22.1184 MHz internal RC oscillator and a slow 10 kHz internal RC oscillator. It also holds the PLL reference select and two power-down control bits. Software writes these through a simple valid/address/data port, and the current contents can always be read back combinationally.

When the CPU signals wait-for-interrupt while both power-down bits are set, the block enters power-down. In power-down the crystal and fast RC enables are forced low. A wake-up request, passed through a configurable synchronizer, first restores those enables to their register values. The power-down flag then clears one clock later.

The block also gates source changes for the system clock multiplexer. A change is granted only when the current source and the requested source are both enabled and report stable. The PLL counts as enabled when the source feeding its reference is enabled. A request that cannot be granted waits, and it is granted automatically once the condition holds.

Top module: `pwr_clk_ctl`

## Requirements
- R1: After reset, the power register reads 0x0000000C and the PLL register reads 0. At the outputs, `xtal_en`=0, `frc_en`=1, `slow_en`=1, `pll_ref_sel`=0, `pd_active`=0 and `cur_sel`=2.
- R2: Power register (address 0) field positions: bit 0 enables the crystal, bit 2 the fast RC, bit 3 the slow RC, bit 7 arms power-down and bit 8 is wait-for-CPU. PLL register (address 1): bit 19 is the PLL reference. A write takes effect at the next clock edge. Reads return only these bits, with all other bits 0. An unmapped address reads 0.
- R3: A `wfi_pulse` sampled while bits 7 and 8 are both 1 sets `pd_active` at that edge. With either bit at 0, `wfi_pulse` has no effect.
- R4: While powered down, `xtal_en` and `frc_en` are 0 whatever their register bits hold. `slow_en` follows bit 0x3 of the power register.
- R5: `wake_req` is taken in by a WAKE_SYNC-stage synchronizer (default 2). On the (WAKE_SYNC+1)-th edge after it is first sampled, `xtal_en` and `frc_en` return to their register values. `pd_active` clears one edge after that. Outside power-down, `wake_req` has no effect.
- R6: `pll_ref_sel` equals PLL register bit 19. A value of 0 selects the crystal and 1 selects the fast RC.
- R7: Source codes are 0 crystal, 1 PLL, 2 fast RC and 3 slow RC. A source is enabled if its enable output is 1. The PLL is enabled if the enable of its selected reference is 1. When both the current and the requested source are enabled and stable, `cur_sel` takes the requested code at the edge where `sw_req` is sampled.
- R8: A request that fails the R7 condition is held pending, and `cur_sel` keeps its value. The held request completes at the first edge where the condition holds. A newer request replaces the pending one.
- R9: `sw_ok` is 1 exactly when a request (new or pending) exists and meets the R7 condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Write address |
| bus_wdata | input | DATA_W | Write data |
| bus_raddr | input | ADDR_W | Read address |
| bus_rdata | output | DATA_W | Read data (combinational) |
| wfi_pulse | input | 1 | CPU wait-for-interrupt pulse |
| wake_req | input | 1 | Wake-up interrupt request |
| src_stable | input | 4 | Stable flag per source, indexed by source code |
| sw_req | input | 1 | Clock source change request |
| sw_sel | input | 2 | Requested source code |
| xtal_en | output | 1 | Crystal oscillator enable |
| frc_en | output | 1 | Fast RC oscillator enable |
| slow_en | output | 1 | Slow RC oscillator enable |
| pll_ref_sel | output | 1 | PLL reference select |
| pd_active | output | 1 | Power-down state flag |
| cur_sel | output | 2 | Granted system clock source |
| sw_ok | output | 1 | Switch permitted this cycle |

## Verification
The register port is swept over all 32 combinations of the five power register bits, with junk written into the undefined bit positions. This separates correct field decoding from shifted or unmasked storage.

All four combinations of the two power-down bits are tried with a wait-for-interrupt pulse. Only the combination with both bits set may power down, and that one is followed through the wake sequence edge by edge. This distinguishes an OR from an AND of the bits, and it also catches an off-by-one in the synchronizer or in the flag delay.

Source switching is swept over every current source, requested source and stable pattern, under four crystal-enable and PLL-reference settings. The expected grant is computed arithmetically. Each refused request is then released by restoring stability or enables, which shows whether it was held pending or dropped.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
   localparam int NSRC  = 4;
   localparam int SEL_W = 2;

   typedef enum logic [SEL_W-1:0] {
      SRC_XTAL = 2'd0,
      SRC_PLL  = 2'd1,
      SRC_FRC  = 2'd2,
      SRC_SLOW = 2'd3
   } src_e;

   typedef enum logic [1:0] {
      PD_RUN  = 2'd0,
      PD_DOWN = 2'd1,
      PD_WAKE = 2'd2
   } pd_state_e;

   typedef struct packed {
      logic xtal_on;
      logic frc_on;
      logic slow_on;
      logic pd_arm;
      logic pd_wait_cpu;
      logic pll_ref;
   } ctl_t;
endpackage

// File: rtl/pcc_regs.sv
module pcc_regs
   import pcc_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 4,
   parameter int PWR_ADDR   = 0,
   parameter int PLL_ADDR   = 1,
   parameter int XTAL_BIT   = 0,
   parameter int FRC_BIT    = 2,
   parameter int SLOW_BIT   = 3,
   parameter int ARM_BIT    = 7,
   parameter int WAIT_BIT   = 8,
   parameter int PLLREF_BIT = 19
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output ctl_t              ctl
);
   localparam logic [ADDR_W-1:0] PWR_A = ADDR_W'(PWR_ADDR);
   localparam logic [ADDR_W-1:0] PLL_A = ADDR_W'(PLL_ADDR);

   ctl_t ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q.xtal_on     <= 1'b0;
         ctl_q.frc_on      <= 1'b1;
         ctl_q.slow_on     <= 1'b1;
         ctl_q.pd_arm      <= 1'b0;
         ctl_q.pd_wait_cpu <= 1'b0;
         ctl_q.pll_ref     <= 1'b0;
      end else if (wr_en) begin
         if (wr_addr == PWR_A) begin
            ctl_q.xtal_on     <= wr_data[XTAL_BIT];
            ctl_q.frc_on      <= wr_data[FRC_BIT];
            ctl_q.slow_on     <= wr_data[SLOW_BIT];
            ctl_q.pd_arm      <= wr_data[ARM_BIT];
            ctl_q.pd_wait_cpu <= wr_data[WAIT_BIT];
         end else if (wr_addr == PLL_A) begin
            ctl_q.pll_ref <= wr_data[PLLREF_BIT];
         end
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == PWR_A) begin
         rd_data[XTAL_BIT] = ctl_q.xtal_on;
         rd_data[FRC_BIT]  = ctl_q.frc_on;
         rd_data[SLOW_BIT] = ctl_q.slow_on;
         rd_data[ARM_BIT]  = ctl_q.pd_arm;
         rd_data[WAIT_BIT] = ctl_q.pd_wait_cpu;
      end else if (rd_addr == PLL_A) begin
         rd_data[PLLREF_BIT] = ctl_q.pll_ref;
      end
   end

   assign ctl = ctl_q;
endmodule

// File: rtl/pcc_pd_fsm.sv
module pcc_pd_fsm
   import pcc_pkg::*;
#(
   parameter int WAKE_SYNC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wfi,
   input  logic wake,
   input  logic arm,
   input  logic wait_cpu,
   output logic pd_down,
   output logic pd_flag
);
   logic      wake_s;
   pd_state_e st_q, st_d;

   generate
      if (WAKE_SYNC == 0) begin : g_nosync
         assign wake_s = wake;
      end else begin : g_sync
         logic [WAKE_SYNC-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh_q <= '0;
            end else begin
               sh_q[0] <= wake;
               for (int i = 1; i < WAKE_SYNC; i++) sh_q[i] <= sh_q[i-1];
            end
         end
         assign wake_s = sh_q[WAKE_SYNC-1];
      end
   endgenerate

   always_comb begin
      st_d = st_q;
      case (st_q)
         PD_RUN:  if (wfi && arm && wait_cpu) st_d = PD_DOWN;
         PD_DOWN: if (wake_s) st_d = PD_WAKE;
         PD_WAKE: st_d = PD_RUN;
         default: st_d = PD_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= PD_RUN;
      else        st_q <= st_d;
   end

   assign pd_down = (st_q == PD_DOWN);
   assign pd_flag = (st_q != PD_RUN);
endmodule

// File: rtl/pcc_sw_gate.sv
module pcc_sw_gate
   import pcc_pkg::*;
#(
   parameter int              N         = NSRC,
   parameter int              SW        = SEL_W,
   parameter logic [SW-1:0]   RESET_SEL = SW'(2),
   parameter bit              HOLD_REQ  = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  src_en,
   input  logic [N-1:0]  src_stable,
   input  logic          req,
   input  logic [SW-1:0] req_sel,
   output logic [SW-1:0] cur_sel,
   output logic [SW-1:0] tgt_sel,
   output logic          ok
);
   logic [SW-1:0] cur_q;
   logic          pend_q;
   logic [SW-1:0] pend_sel_q;
   logic [N-1:0]  ready;
   logic          any_req;

   assign ready   = src_en & src_stable;
   assign any_req = req | pend_q;
   assign tgt_sel = req ? req_sel : pend_sel_q;
   assign ok      = any_req && ready[cur_q] && ready[tgt_sel];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur_q <= RESET_SEL;
      else if (ok) cur_q <= tgt_sel;
   end

   generate
      if (HOLD_REQ) begin : g_hold
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pend_q     <= 1'b0;
               pend_sel_q <= '0;
            end else if (ok) begin
               pend_q <= 1'b0;
            end else if (req) begin
               pend_q     <= 1'b1;
               pend_sel_q <= req_sel;
            end
         end
      end else begin : g_drop
         assign pend_q     = 1'b0;
         assign pend_sel_q = '0;
      end
   endgenerate

   assign cur_sel = cur_q;
endmodule

// File: rtl/pwr_clk_ctl.sv
module pwr_clk_ctl
   import pcc_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 4,
   parameter int PWR_ADDR   = 0,
   parameter int PLL_ADDR   = 1,
   parameter int XTAL_BIT   = 0,
   parameter int FRC_BIT    = 2,
   parameter int SLOW_BIT   = 3,
   parameter int ARM_BIT    = 7,
   parameter int WAIT_BIT   = 8,
   parameter int PLLREF_BIT = 19,
   parameter int WAKE_SYNC  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [ADDR_W-1:0] bus_raddr,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              wfi_pulse,
   input  logic              wake_req,
   input  logic [NSRC-1:0]   src_stable,
   input  logic              sw_req,
   input  logic [SEL_W-1:0]  sw_sel,
   output logic              xtal_en,
   output logic              frc_en,
   output logic              slow_en,
   output logic              pll_ref_sel,
   output logic              pd_active,
   output logic [SEL_W-1:0]  cur_sel,
   output logic              sw_ok
);
   localparam int MAX_BIT = PLLREF_BIT > WAIT_BIT ? PLLREF_BIT : WAIT_BIT;

   generate
      if (MAX_BIT >= DATA_W || ARM_BIT >= DATA_W) begin : g_bad_bit
         $error("register bit position outside DATA_W");
      end
      if (PWR_ADDR == PLL_ADDR || PWR_ADDR >= (1 << ADDR_W) || PLL_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("register addresses must be distinct and fit ADDR_W");
      end
      if (WAKE_SYNC < 0 || WAKE_SYNC > 4) begin : g_bad_sync
         $error("WAKE_SYNC must be 0..4");
      end
   endgenerate

   ctl_t            ctl;
   logic            pd_down;
   logic [NSRC-1:0] src_on;
   logic [SEL_W-1:0] sw_tgt;
   logic            arm_q, wait_q, xtal_bit, frc_bit;

   pcc_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PWR_ADDR(PWR_ADDR), .PLL_ADDR(PLL_ADDR),
      .XTAL_BIT(XTAL_BIT), .FRC_BIT(FRC_BIT), .SLOW_BIT(SLOW_BIT),
      .ARM_BIT(ARM_BIT), .WAIT_BIT(WAIT_BIT), .PLLREF_BIT(PLLREF_BIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .wr_addr(bus_addr),
      .wr_data(bus_wdata), .rd_addr(bus_raddr), .rd_data(bus_rdata), .ctl(ctl)
   );

   assign arm_q    = ctl.pd_arm;
   assign wait_q   = ctl.pd_wait_cpu;
   assign xtal_bit = ctl.xtal_on;
   assign frc_bit  = ctl.frc_on;

   pcc_pd_fsm #(.WAKE_SYNC(WAKE_SYNC)) u_pd (
      .clk(clk), .rst_n(rst_n), .wfi(wfi_pulse), .wake(wake_req),
      .arm(arm_q), .wait_cpu(wait_q), .pd_down(pd_down), .pd_flag(pd_active)
   );

   assign xtal_en     = xtal_bit & ~pd_down;
   assign frc_en      = frc_bit & ~pd_down;
   assign slow_en     = ctl.slow_on;
   assign pll_ref_sel = ctl.pll_ref;

   always_comb begin
      src_on           = '0;
      src_on[SRC_XTAL] = xtal_en;
      src_on[SRC_PLL]  = pll_ref_sel ? frc_en : xtal_en;
      src_on[SRC_FRC]  = frc_en;
      src_on[SRC_SLOW] = slow_en;
   end

   pcc_sw_gate #(.N(NSRC), .SW(SEL_W), .RESET_SEL(SRC_FRC), .HOLD_REQ(1'b1)) u_sw (
      .clk(clk), .rst_n(rst_n), .src_en(src_on), .src_stable(src_stable),
      .req(sw_req), .req_sel(sw_sel), .cur_sel(cur_sel), .tgt_sel(sw_tgt), .ok(sw_ok)
   );
endmodule

// File: rtl/pcc_chk.sv
module pcc_chk
   import pcc_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             wfi_pulse,
   input logic             arm_q,
   input logic             wait_q,
   input logic             pd_active,
   input logic             pd_down,
   input logic             xtal_en,
   input logic             frc_en,
   input logic             xtal_bit,
   input logic             frc_bit,
   input logic [SEL_W-1:0] cur_sel,
   input logic [SEL_W-1:0] sw_tgt,
   input logic             sw_ok,
   input logic [NSRC-1:0]  src_stable
);
   // R3
   pd_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pd_active) |-> $past(wfi_pulse && arm_q && wait_q));

   // R4
   pd_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pd_down |-> (!xtal_en && !frc_en));

   // R5
   pd_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pd_active) |-> (xtal_en == xtal_bit && frc_en == frc_bit));

   // R8
   sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_sel != $past(cur_sel)) |-> $past(sw_ok));

   // R9
   sw_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sw_ok |-> (src_stable[cur_sel] && src_stable[sw_tgt]));
endmodule

bind pwr_clk_ctl pcc_chk u_chk (
   .clk(clk), .rst_n(rst_n), .wfi_pulse(wfi_pulse), .arm_q(arm_q), .wait_q(wait_q),
   .pd_active(pd_active), .pd_down(pd_down), .xtal_en(xtal_en), .frc_en(frc_en),
   .xtal_bit(xtal_bit), .frc_bit(frc_bit), .cur_sel(cur_sel), .sw_tgt(sw_tgt),
   .sw_ok(sw_ok), .src_stable(src_stable)
);

// File: tb/sim_pwr_clk_ctl.sv
module sim_pwr_clk_ctl;
   localparam int CLK_PERIOD = 10;
   localparam int WS = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [3:0]  bus_raddr = '0;
   logic [31:0] bus_rdata;
   logic        wfi_pulse = 1'b0;
   logic        wake_req = 1'b0;
   logic [3:0]  src_stable = 4'hF;
   logic        sw_req = 1'b0;
   logic [1:0]  sw_sel = '0;
   logic        xtal_en, frc_en, slow_en, pll_ref_sel, pd_active, sw_ok;
   logic [1:0]  cur_sel;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwr_clk_ctl #(.WAKE_SYNC(WS)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
      .wfi_pulse(wfi_pulse), .wake_req(wake_req), .src_stable(src_stable),
      .sw_req(sw_req), .sw_sel(sw_sel), .xtal_en(xtal_en), .frc_en(frc_en),
      .slow_en(slow_en), .pll_ref_sel(pll_ref_sel), .pd_active(pd_active),
      .cur_sel(cur_sel), .sw_ok(sw_ok)
   );

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      tick();
      bus_wr = 1'b0;
   endtask

   function automatic logic [31:0] pwr_word(input bit x, input bit f, input bit s, input bit a, input bit w);
      return (32'(x) << 0) | (32'(f) << 2) | (32'(s) << 3) | (32'(a) << 7) | (32'(w) << 8);
   endfunction

   function automatic bit src_enabled(input int i, input bit xen, input bit rf);
      case (i)
         0: return xen;
         1: return rf ? 1'b1 : xen;
         default: return 1'b1;
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      bus_raddr = 4'd0; #1;
      chk("R1 pwr read", bus_rdata, 32'h0000_000C);
      bus_raddr = 4'd1; #1;
      chk("R1 pll read", bus_rdata, 32'h0);
      chk("R1 enables", {29'b0, xtal_en, frc_en, slow_en}, 32'b011);
      chk("R1 pll_ref/pd", {30'b0, pll_ref_sel, pd_active}, 32'b0);
      chk("R1 cur_sel", 32'(cur_sel), 32'd2);

      // R2 sweep of power register fields, with junk in undefined bits
      for (int v = 0; v < 32; v++) begin
         logic [31:0] w;
         w = pwr_word(v[0], v[1], v[2], v[3], v[4]);
         wr(4'd0, w | 32'hA5A5_0030);
         bus_raddr = 4'd0; #1;
         chk("R2 pwr readback", bus_rdata, w);
         chk("R2 xtal_en", 32'(xtal_en), 32'(v[0]));
         chk("R2 frc_en", 32'(frc_en), 32'(v[1]));
         chk("R4 slow_en", 32'(slow_en), 32'(v[2]));
      end
      bus_raddr = 4'd5; #1;
      chk("R2 unmapped read", bus_rdata, 32'h0);

      // R6 PLL reference
      wr(4'd1, 32'hFFFF_FFFF);
      bus_raddr = 4'd1; #1;
      chk("R6 pll read", bus_rdata, 32'h0008_0000);
      chk("R6 pll_ref_sel high", 32'(pll_ref_sel), 32'd1);
      wr(4'd1, 32'hFFF7_FFFF);
      chk("R6 pll_ref_sel low", 32'(pll_ref_sel), 32'd0);

      // R3 / R4 / R5 power-down sweep
      for (int c = 0; c < 4; c++) begin
         bit enter;
         enter = (c == 3);
         wr(4'd0, pwr_word(1, 1, 1, c[0], c[1]));
         wfi_pulse = 1'b1;
         tick();
         wfi_pulse = 1'b0;
         chk("R3 pd entry", 32'(pd_active), 32'(enter));
         chk("R4 xtal forced", 32'(xtal_en), 32'(!enter));
         chk("R4 frc forced", 32'(frc_en), 32'(!enter));
         chk("R4 slow kept", 32'(slow_en), 32'd1);
         if (enter) begin
            repeat (5) tick();
            chk("R5 stays down", 32'(pd_active), 32'd1);
            wake_req = 1'b1;
            tick();
            wake_req = 1'b0;
            repeat (WS - 1) tick();
            chk("R5 still forced", 32'(xtal_en), 32'd0);
            tick();
            chk("R5 enables restored", {30'b0, xtal_en, frc_en}, 32'b11);
            chk("R5 flag held", 32'(pd_active), 32'd1);
            tick();
            chk("R5 flag cleared", 32'(pd_active), 32'd0);
         end else begin
            wake_req = 1'b1;
            tick();
            wake_req = 1'b0;
            repeat (WS + 2) tick();
            chk("R5 wake ignored", {29'b0, pd_active, xtal_en, frc_en}, 32'b011);
         end
      end
      wr(4'd0, pwr_word(1, 1, 1, 0, 0));

      // R7 / R8 / R9 switch sweep
      for (int cfg = 0; cfg < 4; cfg++) begin
         for (int cu = 0; cu < 4; cu++) begin
            for (int tg = 0; tg < 4; tg++) begin
               for (int s = 0; s < 16; s++) begin
                  bit xen, rf, p1, p2;
                  logic [3:0] sv;
                  xen = cfg[0]; rf = cfg[1]; sv = 4'(s);
                  wr(4'd0, pwr_word(1, 1, 1, 0, 0));
                  src_stable = 4'hF;
                  sw_req = 1'b1; sw_sel = 2'(cu);
                  tick();
                  sw_req = 1'b0;
                  chk("R7 setup", 32'(cur_sel), 32'(cu));
                  wr(4'd0, pwr_word(xen, 1, 1, 0, 0));
                  wr(4'd1, 32'(rf) << 19);
                  p1 = sv[cu] && sv[tg] && src_enabled(cu, xen, rf) && src_enabled(tg, xen, rf);
                  src_stable = sv;
                  sw_req = 1'b1; sw_sel = 2'(tg);
                  #1;
                  chk("R9 sw_ok", 32'(sw_ok), 32'(p1));
                  tick();
                  sw_req = 1'b0;
                  chk("R7 grant", 32'(cur_sel), p1 ? 32'(tg) : 32'(cu));
                  if (!p1) begin
                     tick();
                     chk("R8 held", 32'(cur_sel), 32'(cu));
                     src_stable = 4'hF;
                     p2 = src_enabled(cu, xen, rf) && src_enabled(tg, xen, rf);
                     tick();
                     chk("R8 pending completes", 32'(cur_sel), p2 ? 32'(tg) : 32'(cu));
                     if (!p2) begin
                        wr(4'd0, pwr_word(1, 1, 1, 0, 0));
                        tick();
                        chk("R8 completes after enable", 32'(cur_sel), 32'(tg));
                     end
                  end
               end
            end
         end
      end

      // R8 newer request replaces pending
      src_stable = 4'b1011;
      sw_req = 1'b1; sw_sel = 2'd2;
      tick();
      sw_sel = 2'd3;
      tick();
      sw_req = 1'b0;
      src_stable = 4'hF;
      tick();
      chk("R8 replaced request", 32'(cur_sel), 32'd3);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule